// File: doc/BRIEF.md
# Keyed Flash Word Programmer

This block lets a processor program one 24-bit instruction word into a small on-chip program-flash array through a simple register bus. Software picks a page, loads the word into a two-part staging latch, chooses the single-word operation and write-enable in the control register, and then writes a two-value key. Only a start request written straight after that key is accepted. An accepted start runs a program cycle of fixed length. The new word is ANDed into the stored word, because programming can only clear bits of an erased location.

Bus writes take effect on the clock edge at which `bus_we` is high. Reads are combinational from `bus_addr`. The register bus has no handshake and no back-pressure. While a cycle runs, `busy` is high and every bus write is dropped, so software polls `busy` or waits for `done`. `hold` asks the requester to idle for two cycles after a start is accepted.

Top module: `flash_word_prog`

## Requirements
- R1: After reset, the page, latch and control registers read 0, `busy`, `done`, `hold` and `error` are 0, and every array word reads 0xFFFFFF.
- R2: A start request is a write to control (address 3) with bit 15 set. It is accepted only when the two writes just before it were key writes (address 4) of 0x00000055 and then 0x000000AA.
- R3: Any other write between the first key value and the second, or between the second key value and the start request, cancels the unlock. A start request made without a complete unlock starts no cycle and sets `error` (control bit 13).
- R4: The start write must also carry write-enable (bit 14) = 1 and operation code (bits [3:0]) = 0011. Otherwise no cycle starts and `error` is set. An accepted start clears `error`. Every control write stores bits 14 and [3:0].
- R5: A write to address 1 stores the offset from wdata[31:16] and the low word from wdata[15:0]. A write to address 2 stores the offset from wdata[31:16] and the high byte from wdata[7:0], and ignores wdata[15:8]. Address 0 holds the 8-bit page. The target word is {page[PG_IDX_W-1:0], offset[OFF_IDX_W-1:0]}, and address 5 reads it back as {8'h0, word}.
- R6: A program cycle replaces the target word with (stored word AND {high byte, low word}).
- R7: `busy` rises in the cycle after the accepted start write and stays high for exactly CYCLES cycles (default 16). Control bit 15 reads as `busy`. After the cycle the start bit reads 0 and write-enable keeps its value.
- R8: `done` is high for exactly one cycle, the cycle in which `busy` has just fallen, and the array already holds the new word in that cycle.
- R9: `hold` is high for the two cycles that follow an accepted start write.
- R10: Page, latch, control and key writes made while `busy` is high have no effect.
- R11: Address 4 (key) always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| busy | output | 1 | Program cycle running |
| done | output | 1 | One-cycle completion pulse |
| hold | output | 1 | Requester idle request after start |
| error | output | 1 | Last start request was refused |

## Verification
The assertions check on every cycle that:
- a start without unlock, or with a bad operation code or write-enable, never raises `busy` and always sets `error`;
- `busy` lasts exactly CYCLES cycles and is followed by a single `done` pulse;
- `hold` follows each start;
- the key register reads zero and the start bit mirrors `busy`;
- the page stays stable during a cycle.

Only the bench scenarios can show the data path: the AND of a second program into an already programmed word, the page-and-offset indexing, and the cancelling of an unlock by an intervening write. They also show that writes dropped while busy, including a key write, leave no trace that a later sequence could use.

// File: rtl/flash_prog_pkg.sv
package flash_prog_pkg;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int WORD_W = 24;

  // register selects
  typedef enum logic [ADDR_W-1:0] {
    SEL_PAGE   = 3'd0,
    SEL_LAT_LO = 3'd1,
    SEL_LAT_HI = 3'd2,
    SEL_CTRL   = 3'd3,
    SEL_KEY    = 3'd4,
    SEL_ARRAY  = 3'd5
  } reg_sel_e;

  // control field positions
  localparam int CTL_START = 15;
  localparam int CTL_WREN  = 14;
  localparam int CTL_ERR   = 13;
  localparam logic [3:0] OP_ONE_WORD = 4'b0011;

  // unlock key values, in required order
  localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h0000_0055;
  localparam logic [DATA_W-1:0] KEY_SECOND = 32'h0000_00AA;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_HALF  = 2'd1,
    UNL_ARMED = 2'd2
  } unlock_e;

endpackage

// File: rtl/fp_unlock.sv
// Tracks the two-step key sequence. Every accepted bus write advances or
// cancels it; only the write right after the second key sees it armed.
module fp_unlock
  import flash_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              is_key,
  input  logic [DATA_W-1:0] key_val,
  output logic              armed
);

  unlock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (wr_en) begin
      if (is_key && key_val == KEY_FIRST)
        state_d = UNL_HALF;
      else if (is_key && key_val == KEY_SECOND && state_q == UNL_HALF)
        state_d = UNL_ARMED;
      else
        state_d = UNL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UNL_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == UNL_ARMED);

endmodule

// File: rtl/fp_sequencer.sv
// Times a program cycle: busy for CYCLES cycles, commit on the last one,
// done one cycle later, and a short hold window after launch.
module fp_sequencer #(
  parameter int CYCLES      = 16,
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  output logic busy,
  output logic commit,
  output logic done,
  output logic hold
);

  localparam int CNT_W  = $clog2(CYCLES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [HOLD_W-1:0] hold_q;
  logic              busy_q, done_q;

  assign commit = busy_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= commit;
      if (launch) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(CYCLES - 1);
      end else if (commit) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (launch)         hold_q <= HOLD_W'(HOLD_CYCLES);
    else if (hold_q != '0)   hold_q <= hold_q - 1'b1;
  end

  assign busy = busy_q;
  assign done = done_q;
  assign hold = (hold_q != '0);

endmodule

// File: rtl/fp_array.sv
// Behavioural program-flash array: erased to all ones, programming ANDs.
module fp_array #(
  parameter int IDX_W  = 6,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word
);

  localparam int DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] rows [DEPTH];

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '1;
      else if (wr_en && wr_idx == IDX_W'(r))
        word_q <= word_q & wr_word;
    end
    assign rows[r] = word_q;
  end

  assign rd_word = rows[rd_idx];

endmodule

// File: rtl/flash_word_prog.sv
module flash_word_prog
  import flash_prog_pkg::*;
#(
  parameter int CYCLES      = 16,
  parameter int HOLD_CYCLES = 2,
  parameter int PG_IDX_W    = 2,
  parameter int OFF_IDX_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy,
  output logic              done,
  output logic              hold,
  output logic              error
);

  localparam int IDX_W = PG_IDX_W + OFF_IDX_W;

  reg_sel_e          sel;
  logic              wr_ok, start_req, launch, commit, unl_armed;
  logic [7:0]        page_q;
  logic [15:0]       off_q, lo_q;
  logic [7:0]        hi_q;
  logic              wren_q, err_q;
  logic [3:0]        op_q;
  logic [IDX_W-1:0]  tgt_idx;
  logic [WORD_W-1:0] arr_word;

  assign sel       = reg_sel_e'(bus_addr);
  // all writes are dropped while a cycle runs
  assign wr_ok     = bus_we && !busy;
  assign start_req = wr_ok && sel == SEL_CTRL && bus_wdata[CTL_START];
  assign launch    = start_req && unl_armed && bus_wdata[CTL_WREN]
                     && bus_wdata[3:0] == OP_ONE_WORD;

  fp_unlock u_unlock (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_ok),
    .is_key  (sel == SEL_KEY),
    .key_val (bus_wdata),
    .armed   (unl_armed)
  );

  fp_sequencer #(.CYCLES(CYCLES), .HOLD_CYCLES(HOLD_CYCLES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .launch (launch),
    .busy   (busy),
    .commit (commit),
    .done   (done),
    .hold   (hold)
  );

  // staging registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (wr_ok) begin
      case (sel)
        SEL_PAGE:   page_q <= bus_wdata[7:0];
        SEL_LAT_LO: begin
          off_q <= bus_wdata[31:16];
          lo_q  <= bus_wdata[15:0];
        end
        SEL_LAT_HI: begin
          off_q <= bus_wdata[31:16];
          hi_q  <= bus_wdata[7:0];
        end
        default: ;
      endcase
    end
  end

  // control fields and refusal flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      op_q   <= '0;
      err_q  <= 1'b0;
    end else begin
      if (wr_ok && sel == SEL_CTRL) begin
        wren_q <= bus_wdata[CTL_WREN];
        op_q   <= bus_wdata[3:0];
      end
      if (launch)         err_q <= 1'b0;
      else if (start_req) err_q <= 1'b1;
    end
  end

  assign tgt_idx = {page_q[PG_IDX_W-1:0], off_q[OFF_IDX_W-1:0]};

  fp_array #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (commit),
    .wr_idx  (tgt_idx),
    .wr_word ({hi_q, lo_q}),
    .rd_idx  (tgt_idx),
    .rd_word (arr_word)
  );

  always_comb begin
    bus_rdata = '0;
    case (sel)
      SEL_PAGE:   bus_rdata = {24'h0, page_q};
      SEL_LAT_LO: bus_rdata = {off_q, lo_q};
      SEL_LAT_HI: bus_rdata = {off_q, 8'h0, hi_q};
      SEL_CTRL:   bus_rdata = {16'h0, busy, wren_q, err_q, 9'h0, op_q};
      SEL_KEY:    bus_rdata = '0;
      SEL_ARRAY:  bus_rdata = {8'h0, arr_word};
      default:    bus_rdata = '0;
    endcase
  end

  assign error = err_q;

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
  parameter int CYCLES = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_we,
  input logic [31:0] bus_rdata,
  input logic        busy,
  input logic        done,
  input logic        hold,
  input logic        error,
  input logic        armed,
  input logic [7:0]  page
);

  int unsigned run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  logic start_wr;
  assign start_wr = bus_we && bus_addr == 3'd3 && bus_wdata[15] && !busy;

  assert_locked_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && !armed) |=> (!busy && error));

  assert_bad_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && (bus_wdata[3:0] != 4'b0011 || !bus_wdata[14])) |=> (!busy && error));

  assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == CYCLES));

  assert_start_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd3) |-> (bus_rdata[15] == busy));

  assert_done_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> hold);

  assert_hold_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> hold);

  assert_page_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(page));

  assert_key_reads_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 3'd4) |-> (bus_rdata == 32'h0));

endmodule

bind flash_word_prog fp_checker #(.CYCLES(CYCLES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .busy      (busy),
  .done      (done),
  .hold      (hold),
  .error     (error),
  .armed     (unl_armed),
  .page      (page_q)
);

// File: tb/flash_word_prog_tb.sv
`timescale 1ns/1ps
module flash_word_prog_tb_top;

  localparam int CYC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        busy, done, hold, error;

  int n_checks = 0;
  int n_errs = 0;

  always #2.5 clk = ~clk;

  flash_word_prog #(.CYCLES(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .busy(busy), .done(done),
    .hold(hold), .error(error)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_page, m_off, m_lo, m_hi, m_wren, m_op, m_err;
  int m_busy, m_left, m_done, m_hold, m_key;
  int m_mem[64];

  function automatic int m_idx();
    return (m_page % 4) * 16 + (m_off % 16);
  endfunction

  always @(posedge clk) begin
    int was_busy;
    int d;
    if (!rst_n) begin
      m_page = 0; m_off = 0; m_lo = 0; m_hi = 0; m_wren = 0; m_op = 0;
      m_err = 0; m_busy = 0; m_left = 0; m_done = 0; m_hold = 0; m_key = 0;
      foreach (m_mem[i]) m_mem[i] = 'hFFFFFF;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_hold > 0) m_hold--;
      if (m_busy != 0) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          m_done = 1;
          m_mem[m_idx()] = m_mem[m_idx()] & ((m_hi << 16) | m_lo);
        end
      end
      if (bus_we && was_busy == 0) begin
        d = int'(bus_wdata);
        case (bus_addr)
          3'd0: m_page = d & 'hFF;
          3'd1: begin m_off = int'(bus_wdata[31:16]); m_lo = d & 'hFFFF; end
          3'd2: begin m_off = int'(bus_wdata[31:16]); m_hi = d & 'hFF; end
          3'd3: begin
            m_wren = int'(bus_wdata[14]);
            m_op = d & 'hF;
            if (bus_wdata[15]) begin
              if (m_key == 2 && m_wren == 1 && m_op == 3) begin
                m_busy = 1; m_left = CYC; m_hold = 2; m_err = 0;
              end else m_err = 1;
            end
          end
          default: ;
        endcase
        if (bus_addr == 3'd4 && bus_wdata == 32'h55) m_key = 1;
        else if (bus_addr == 3'd4 && bus_wdata == 32'hAA && m_key == 1) m_key = 2;
        else m_key = 0;
      end
    end
  end

  function automatic logic [31:0] m_rdata(input logic [2:0] a);
    case (a)
      3'd0: return 32'(m_page);
      3'd1: return 32'((m_off << 16) | m_lo);
      3'd2: return 32'((m_off << 16) | m_hi);
      3'd3: return 32'((m_busy << 15) | (m_wren << 14) | (m_err << 13) | m_op);
      3'd5: return 32'(m_mem[m_idx()]);
      default: return 32'h0;
    endcase
  endfunction

  // compare against the model every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 model busy", 32'(busy), 32'(m_busy));
      check("R8 model done", 32'(done), 32'(m_done));
      check("R9 model hold", 32'(hold), 32'(m_hold > 0));
      check("R3 model error", 32'(error), 32'(m_err));
      check("R5 model rdata", bus_rdata, m_rdata(bus_addr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic unlock_start(input logic [31:0] ctl);
    wr(3'd3, 32'h4003);
    wr(3'd4, 32'h55);
    wr(3'd4, 32'hAA);
    wr(3'd3, ctl);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_errs++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd(3'd3, v); check("R1 ctrl", v, 32'h0);
    rd(3'd0, v); check("R1 page", v, 32'h0);
    rd(3'd5, v); check("R1 erased", v, 32'hFFFFFF);
    check("R1 outputs", {busy, done, hold, error}, 4'b0);

    // R11 key reads zero
    wr(3'd4, 32'h55);
    rd(3'd4, v); check("R11 key read", v, 32'h0);

    // R5 staging with ignored upper high-byte bits
    wr(3'd0, 32'h1);
    wr(3'd1, {16'd3, 16'h1234});
    wr(3'd2, {16'd3, 16'hAB56});
    rd(3'd2, v); check("R5 high byte", v, {16'd3, 16'h0056});

    // R2 full sequence starts a cycle
    unlock_start(32'hC003);
    @(negedge clk);
    check("R2 started", 32'(busy), 32'h1);
    check("R7 start bit", 32'(bus_rdata[15]), 32'h1);
    n = 0;
    while (busy && n < 200) begin
      n++;
      if (n <= 2) check("R9 hold high", 32'(hold), 32'h1);
      if (n == 3) check("R9 hold low", 32'(hold), 32'h0);
      @(negedge clk);
    end
    check("R7 busy length", 32'(n), 32'(CYC));
    check("R8 done pulse", 32'(done), 32'h1);
    @(negedge clk);
    check("R8 done single", 32'(done), 32'h0);
    rd(3'd5, v); check("R6 programmed", v, 32'h561234);
    rd(3'd3, v); check("R7 ctrl after", v, 32'h4003);

    // R6 second program ANDs into stored word
    wr(3'd1, {16'd3, 16'h00FF});
    wr(3'd2, {16'd3, 16'h00FF});
    unlock_start(32'hC003);
    @(negedge clk);
    wait_idle(n);
    rd(3'd5, v); check("R6 and", v, 32'h560034);

    // R3 interrupted unlock
    wr(3'd4, 32'h55);
    wr(3'd0, 32'h1);
    wr(3'd4, 32'hAA);
    wr(3'd3, 32'hC003);
    @(negedge clk);
    check("R3 no start", 32'(busy), 32'h0);
    check("R3 error", 32'(error), 32'h1);
    rd(3'd5, v); check("R3 array kept", v, 32'h560034);

    // R4 bad op code and missing write-enable
    unlock_start(32'hC004);
    @(negedge clk);
    check("R4 bad op", {31'h0, busy}, 32'h0);
    rd(3'd3, v); check("R4 ctrl", v, 32'h6004);
    unlock_start(32'h8003);
    @(negedge clk);
    check("R4 no wren", {30'h0, busy, error}, 32'h1);

    // R4 accepted start clears error; R10 writes ignored while busy
    wr(3'd1, {16'd3, 16'hFFFF});
    wr(3'd2, {16'd3, 16'h00FF});
    unlock_start(32'hC003);
    @(negedge clk);
    check("R4 error cleared", 32'(error), 32'h0);
    wr(3'd0, 32'h2);
    wr(3'd1, {16'd5, 16'h0});
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h55);
    @(negedge clk);
    wait_idle(n);
    rd(3'd0, v); check("R10 page", v, 32'h1);
    rd(3'd1, v); check("R10 latch", v, {16'd3, 16'hFFFF});
    rd(3'd3, v); check("R10 ctrl", v, 32'h4003);
    wr(3'd4, 32'hAA);
    wr(3'd3, 32'hC003);
    @(negedge clk);
    check("R10 key ignored", {30'h0, busy, error}, 32'h1);

    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule